// File: doc/BRIEF.md
# Reconfiguration Instruction Co-processor

This unit sits beside a small CPU and executes three custom R-type instructions that move configuration words. The CPU hands over an instruction word and two register operands with a valid/ready handshake. It stays stalled until the unit asserts ready, which happens only once the transfer has finished. At that moment the unit returns a result for the destination register.

The first instruction copies words from a local bitstream buffer to a 32-bit configuration port. The second reads words from the port into the buffer. The third moves words from a streaming FIFO to the port, in the manner of a DMA engine. Outside logic fills that FIFO through a plain write interface. Buffered data lets software patch individual words between a read and a write-back, for example to flip one bit for fault injection or to correct one. A full frame of 202 words and an 11-word capture command fit in a single instruction.

Top module: `recfg_unit`

## Requirements
- R1: After reset, insnReady, resultWr and cfgEn are low and fifoFull is low.
- R2: An instruction is claimed only when insnWord[6:0] equals 7'b0101011. funct7 (insnWord[31:25]) selects the operation: 7'h01 buffer-to-port write, 7'h02 port-to-buffer read, 7'h03 FIFO-to-port stream. funct3 (insnWord[14:12]) bit 2 marks rd valid, bit 1 marks rs1 valid and bit 0 marks rs2 valid.
- R3: A buffer-to-port write with start address opA and count opB drives cfgEn and cfgWrite high for exactly opB consecutive cycles. cfgWdata carries the buffer words at opA, opA+1, and so on. insnReady follows in the next cycle, so retirement comes opB+1 cycles after the accepting edge.
- R4: A port-to-buffer read drives cfgEn high with cfgWrite low for opB consecutive cycles. The word on cfgRdata one cycle after each strobe is stored at the next sequential buffer address, starting at opA. Retirement comes opB+2 cycles after the accepting edge.
- R5: Buffer addresses wrap modulo the buffer depth (256 by default). A transfer that starts near the top continues at address 0.
- R6: A FIFO-to-port stream sends FIFO words in arrival order. While the FIFO is empty it issues no port cycle and does not advance its count. It retires only after the last word has been sent.
- R7: The FIFO holds FIFO_DEPTH words (16 by default). fifoFull is high when it is full, and a write while full is dropped.
- R8: An unknown funct7 retires in the cycle after acceptance, with resultData equal to 32'hFFFFFFFF and no port cycle.
- R9: A word count of zero retires in the cycle after acceptance, with resultData 0 and no port cycle.
- R10: For a known operation with a non-zero count, resultData equals the word count.
- R11: An operand whose funct3 valid bit is clear is taken as zero. resultWr is high only when the rd-valid bit is set.
- R12: A valid word with any other major opcode is never acknowledged and causes no port cycle.
- R13: insnReady is a single-cycle pulse per instruction and is raised only while insnValid is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| insnValid | input | 1 | Instruction offered by the CPU |
| insnWord | input | 32 | Instruction word |
| opA | input | 32 | rs1 value: buffer start address |
| opB | input | 32 | rs2 value: word count |
| insnReady | output | 1 | Instruction retired (one-cycle pulse) |
| resultWr | output | 1 | Write resultData to rd |
| resultData | output | 32 | Result for rd |
| fifoWrEn | input | 1 | FIFO write strobe |
| fifoWrData | input | 32 | FIFO write word |
| fifoFull | output | 1 | FIFO full; writes are dropped |
| cfgEn | output | 1 | Configuration port cycle strobe |
| cfgWrite | output | 1 | 1 = write cycle, 0 = read cycle |
| cfgWdata | output | 32 | Word written to the port |
| cfgRdata | input | 32 | Word read from the port, one cycle after the read strobe |

## Verification
On every cycle the assertions check the following: the ready pulse lasts one cycle, it appears only while an instruction with the claimed opcode is held, no port cycle overlaps retirement, the FIFO is never popped while empty, and unknown operations return all ones. Only the bench scenarios can show that data is moved correctly. Those scenarios cover buffer contents surviving a read followed by a write-back, address wrap at the top of the buffer, stream order across an empty-FIFO stall, the word dropped on a full FIFO, and retirement latency for each operation and for the zero-count case.

// File: rtl/recfg_pkg.sv
package recfg_pkg;
  localparam logic [6:0] OPC_CUSTOM1 = 7'b0101011;
  localparam logic [6:0] F7_BUF2PORT = 7'h01;
  localparam logic [6:0] F7_PORT2BUF = 7'h02;
  localparam logic [6:0] F7_STREAM   = 7'h03;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BUF2PORT, ST_PORT2BUF, ST_RDTAIL, ST_STREAM, ST_RETIRE
  } ctlState_t;

  typedef struct packed {
    logic loadPtr;
    logic bufToPort;
    logic portRead;
    logic fifoToPort;
  } dpStrobe_t;
endpackage

// File: rtl/recfg_fifo.sv
module recfg_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] headData,
  output logic             full,
  output logic             empty
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [CNT_W-1:0] fill;
  logic doPush, doPop;

  function automatic logic [IDX_W-1:0] nextIdx(input logic [IDX_W-1:0] idx);
    return (idx == IDX_W'(DEPTH - 1)) ? '0 : idx + 1'b1;
  endfunction

  assign full     = (fill == CNT_W'(DEPTH));
  assign empty    = (fill == '0);
  assign doPush   = wrEn && !full;
  assign doPop    = rdEn && !empty;
  assign headData = mem[rdIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrIdx <= nextIdx(wrIdx);
      if (doPop)  rdIdx <= nextIdx(rdIdx);
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrIdx] <= wrData;
  end
endmodule

// File: rtl/recfg_datapath.sv
module recfg_datapath
  import recfg_pkg::*;
#(
  parameter int BUF_DEPTH  = 256,
  parameter int FIFO_DEPTH = 16,
  localparam int ADDR_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              cfgEn,
  output logic              cfgWrite,
  output logic [31:0]       cfgWdata,
  input  logic [31:0]       cfgRdata,
  input  logic              fifoWrEn,
  input  logic [31:0]       fifoWrData,
  output logic              fifoFull,
  output logic              fifoEmpty
);
  logic [31:0]       bufMem [BUF_DEPTH];
  logic [ADDR_W-1:0] rdPtr, capPtr;
  logic              capValid;
  logic [31:0]       fifoHead;

  recfg_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) streamFifo (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (fifoWrEn),
    .wrData   (fifoWrData),
    .rdEn     (strobe.fifoToPort),
    .headData (fifoHead),
    .full     (fifoFull),
    .empty    (fifoEmpty)
  );

  assign cfgEn    = strobe.bufToPort | strobe.portRead | strobe.fifoToPort;
  assign cfgWrite = strobe.bufToPort | strobe.fifoToPort;

  always_comb begin
    if (strobe.fifoToPort)     cfgWdata = fifoHead;
    else if (strobe.bufToPort) cfgWdata = bufMem[rdPtr];
    else                       cfgWdata = '0;
  end

  // Pointers wrap naturally: the buffer depth is a power of two.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr    <= '0;
      capPtr   <= '0;
      capValid <= 1'b0;
    end else begin
      capValid <= strobe.portRead;
      if (strobe.loadPtr)        rdPtr <= startAddr;
      else if (strobe.bufToPort) rdPtr <= rdPtr + 1'b1;
      if (strobe.loadPtr)        capPtr <= startAddr;
      else if (capValid)         capPtr <= capPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (capValid) bufMem[capPtr] <= cfgRdata;
  end
endmodule

// File: rtl/recfg_ctrl.sv
module recfg_ctrl
  import recfg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insnValid,
  input  logic [31:0]       insnWord,
  input  logic [31:0]       opA,
  input  logic [31:0]       opB,
  output logic              insnReady,
  output logic              resultWr,
  output logic [31:0]       resultData,
  input  logic              fifoEmpty,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] startAddr
);
  ctlState_t        state, stateNext;
  logic [CNT_W-1:0] remaining;
  logic [31:0]      result;
  logic             rdFlag;

  logic [6:0]       funct7;
  logic [2:0]       funct3;
  logic             accept;
  logic [31:0]      effA;
  logic [CNT_W-1:0] effCount;
  logic             unusedCtlBits;

  assign funct7   = insnWord[31:25];
  assign funct3   = insnWord[14:12];
  assign accept   = (state == ST_IDLE) && insnValid && (insnWord[6:0] == OPC_CUSTOM1);
  assign effA     = funct3[1] ? opA : '0;
  assign effCount = funct3[0] ? opB[CNT_W-1:0] : '0;
  assign startAddr = effA[ADDR_W-1:0];
  assign unusedCtlBits = ^{insnWord[24:15], insnWord[11:7], effA[31:ADDR_W], opB[31:CNT_W]};

  assign insnReady  = (state == ST_RETIRE);
  assign resultWr   = insnReady && rdFlag;
  assign resultData = result;

  always_comb begin
    strobe            = '0;
    strobe.loadPtr    = accept;
    strobe.bufToPort  = (state == ST_BUF2PORT);
    strobe.portRead   = (state == ST_PORT2BUF);
    strobe.fifoToPort = (state == ST_STREAM) && !fifoEmpty;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (effCount == '0) stateNext = ST_RETIRE;
          else begin
            case (funct7)
              F7_BUF2PORT: stateNext = ST_BUF2PORT;
              F7_PORT2BUF: stateNext = ST_PORT2BUF;
              F7_STREAM:   stateNext = ST_STREAM;
              default:     stateNext = ST_RETIRE;
            endcase
          end
        end
      end
      ST_BUF2PORT: if (remaining == CNT_W'(1)) stateNext = ST_RETIRE;
      ST_PORT2BUF: if (remaining == CNT_W'(1)) stateNext = ST_RDTAIL;
      ST_RDTAIL:   stateNext = ST_RETIRE;
      ST_STREAM:   if (!fifoEmpty && remaining == CNT_W'(1)) stateNext = ST_RETIRE;
      ST_RETIRE:   stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      result    <= '0;
      rdFlag    <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) begin
        remaining <= effCount;
        rdFlag    <= funct3[2];
        if (funct7 == F7_BUF2PORT || funct7 == F7_PORT2BUF || funct7 == F7_STREAM)
          result <= 32'(effCount);
        else
          result <= '1;
      end else if (strobe.bufToPort || strobe.portRead || strobe.fifoToPort) begin
        remaining <= remaining - 1'b1;
      end
    end
  end
endmodule

// File: rtl/recfg_unit.sv
module recfg_unit #(
  parameter int BUF_DEPTH  = 256,
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        insnValid,
  input  logic [31:0] insnWord,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic        insnReady,
  output logic        resultWr,
  output logic [31:0] resultData,
  input  logic        fifoWrEn,
  input  logic [31:0] fifoWrData,
  output logic        fifoFull,
  output logic        cfgEn,
  output logic        cfgWrite,
  output logic [31:0] cfgWdata,
  input  logic [31:0] cfgRdata
);
  localparam int ADDR_W = $clog2(BUF_DEPTH);

  recfg_pkg::dpStrobe_t ctlStrobe;
  logic [ADDR_W-1:0]    startAddr;
  logic                 fifoEmpty;
  logic                 fifoPop;

  assign fifoPop = ctlStrobe.fifoToPort;

  recfg_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .insnValid  (insnValid),
    .insnWord   (insnWord),
    .opA        (opA),
    .opB        (opB),
    .insnReady  (insnReady),
    .resultWr   (resultWr),
    .resultData (resultData),
    .fifoEmpty  (fifoEmpty),
    .strobe     (ctlStrobe),
    .startAddr  (startAddr)
  );

  recfg_datapath #(.BUF_DEPTH(BUF_DEPTH), .FIFO_DEPTH(FIFO_DEPTH)) dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (ctlStrobe),
    .startAddr  (startAddr),
    .cfgEn      (cfgEn),
    .cfgWrite   (cfgWrite),
    .cfgWdata   (cfgWdata),
    .cfgRdata   (cfgRdata),
    .fifoWrEn   (fifoWrEn),
    .fifoWrData (fifoWrData),
    .fifoFull   (fifoFull),
    .fifoEmpty  (fifoEmpty)
  );
endmodule

// File: rtl/recfg_unit_checker.sv
module recfg_unit_checker (
  input logic        clk,
  input logic        rstN,
  input logic        insnValid,
  input logic [31:0] insnWord,
  input logic        insnReady,
  input logic        resultWr,
  input logic [31:0] resultData,
  input logic        cfgEn,
  input logic        fifoPop,
  input logic        fifoEmpty,
  input logic        fifoFull
);
  logic knownOp;
  assign knownOp = (insnWord[31:25] == 7'h01) || (insnWord[31:25] == 7'h02) ||
                   (insnWord[31:25] == 7'h03);

  a_r13_ready_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    insnReady |=> !insnReady);

  a_r13_ready_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    insnReady |-> insnValid);

  a_r12_custom_opcode_only: assert property (@(posedge clk) disable iff (!rstN)
    insnReady |-> (insnWord[6:0] == 7'b0101011));

  a_r8_unknown_all_ones: assert property (@(posedge clk) disable iff (!rstN)
    (insnReady && !knownOp) |-> (resultData == 32'hFFFF_FFFF));

  a_r9_port_quiet_at_retire: assert property (@(posedge clk) disable iff (!rstN)
    insnReady |-> !cfgEn);

  a_r6_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !fifoEmpty);

  a_r7_full_excludes_empty: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));

  a_r11_write_only_on_retire: assert property (@(posedge clk) disable iff (!rstN)
    resultWr |-> insnReady);
endmodule

bind recfg_unit recfg_unit_checker chk (
  .clk        (clk),
  .rstN       (rstN),
  .insnValid  (insnValid),
  .insnWord   (insnWord),
  .insnReady  (insnReady),
  .resultWr   (resultWr),
  .resultData (resultData),
  .cfgEn      (cfgEn),
  .fifoPop    (fifoPop),
  .fifoEmpty  (fifoEmpty),
  .fifoFull   (fifoFull)
);

// File: tb/recfg_unit_test.sv
`timescale 1ns/1ps
module recfg_unit_test;
  localparam logic [6:0] OPC = 7'b0101011;
  localparam int DEPTH = 256;
  localparam int FDEPTH = 16;
  localparam logic [31:0] PAT_BASE = 32'hA500_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic insnValid = 1'b0;
  logic [31:0] insnWord = '0, opA = '0, opB = '0;
  logic insnReady, resultWr;
  logic [31:0] resultData;
  logic fifoWrEn = 1'b0;
  logic [31:0] fifoWrData = '0;
  logic fifoFull, cfgEn, cfgWrite;
  logic [31:0] cfgWdata;
  logic [31:0] cfgRdata = '0;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] expQ[$];
  int expReads = 0;
  int portPat = 0;
  int rdPat = 0;
  logic [31:0] modBuf [DEPTH];

  always #4 clk = ~clk;

  recfg_unit uut (
    .clk(clk), .rstN(rstN), .insnValid(insnValid), .insnWord(insnWord),
    .opA(opA), .opB(opB), .insnReady(insnReady), .resultWr(resultWr),
    .resultData(resultData), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .fifoFull(fifoFull), .cfgEn(cfgEn), .cfgWrite(cfgWrite),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Port model: read data arrives one cycle after the read strobe.
  always @(posedge clk) begin
    if (rstN && cfgEn && !cfgWrite) begin
      cfgRdata <= PAT_BASE + 32'(portPat);
      portPat <= portPat + 1;
    end
  end

  // Every-cycle comparison of port activity against the reference queue.
  always @(negedge clk) begin
    if (rstN && cfgEn) begin
      if (cfgWrite) begin
        if (expQ.size() == 0) check(1'b0, "R3/R6 unexpected port write", cfgWdata, 32'h0);
        else begin
          logic [31:0] e;
          e = expQ.pop_front();
          check(cfgWdata == e, "R3/R5/R6 port write word", cfgWdata, e);
        end
      end else begin
        check(expReads > 0, "R4 unexpected port read", 32'(expReads), 32'd1);
        if (expReads > 0) expReads--;
      end
    end
  end

  task automatic issue(input logic [6:0] f7, input logic [2:0] f3, input logic [31:0] a,
                       input logic [31:0] b, output logic [31:0] res, output logic wr,
                       output int lat);
    @(negedge clk);
    insnWord = {f7, 5'd2, 5'd1, f3, 5'd3, OPC};
    opA = a; opB = b; insnValid = 1'b1; lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!insnReady && lat < 5000);
    res = resultData;
    wr  = resultWr;
    @(posedge clk);
    #1 insnValid = 1'b0;
  endtask

  task automatic pushWord(input logic [31:0] w);
    @(negedge clk);
    fifoWrEn = 1'b1; fifoWrData = w;
    @(negedge clk);
    fifoWrEn = 1'b0;
  endtask

  task automatic readIn(input int addr, input int n, input string req);
    logic [31:0] r; logic w; int lat;
    for (int i = 0; i < n; i++) modBuf[(addr + i) % DEPTH] = PAT_BASE + 32'(rdPat + i);
    rdPat += n;
    expReads += n;
    issue(7'h02, 3'b111, 32'(addr), 32'(n), r, w, lat);
    check(r == 32'(n), {req, " R10 read result"}, r, 32'(n));
    check(lat == n + 2, {req, " R4 read latency"}, 32'(lat), 32'(n + 2));
    check(w == 1'b1, {req, " R11 rd write"}, 32'(w), 32'd1);
  endtask

  task automatic writeOut(input int addr, input int n, input string req);
    logic [31:0] r; logic w; int lat;
    for (int i = 0; i < n; i++) expQ.push_back(modBuf[(addr + i) % DEPTH]);
    issue(7'h01, 3'b111, 32'(addr), 32'(n), r, w, lat);
    check(r == 32'(n), {req, " R10 write result"}, r, 32'(n));
    check(lat == n + 1, {req, " R3 write latency"}, 32'(lat), 32'(n + 1));
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      summary();
    end
  end

  initial begin
    logic [31:0] r; logic w; int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(insnReady == 1'b0, "R1 ready low", 32'(insnReady), 32'd0);
    check(cfgEn == 1'b0, "R1 port idle", 32'(cfgEn), 32'd0);
    check(fifoFull == 1'b0, "R1 fifo not full", 32'(fifoFull), 32'd0);
    check(resultWr == 1'b0, "R1 no rd write", 32'(resultWr), 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4: read a block into the buffer, then copy it back out
    readIn(4, 5, "R2");
    writeOut(4, 5, "R2");
    writeOut(6, 2, "R3 partial");

    // R5 wrap at the top of the buffer
    readIn(250, 10, "R5");
    writeOut(250, 10, "R5");

    // frame-size and capture-size transfers
    readIn(0, 202, "R4 frame");
    writeOut(0, 202, "R3 frame");
    writeOut(17, 11, "R3 capture");

    // R8 unknown funct7
    issue(7'h55, 3'b111, 32'd0, 32'd9, r, w, lat);
    check(r == 32'hFFFF_FFFF, "R8 unknown result", r, 32'hFFFF_FFFF);
    check(lat == 1, "R8 unknown latency", 32'(lat), 32'd1);

    // R9 zero count
    issue(7'h01, 3'b111, 32'd3, 32'd0, r, w, lat);
    check(r == 32'd0, "R9 zero result", r, 32'd0);
    check(lat == 1, "R9 zero latency", 32'(lat), 32'd1);

    // R11 operand and rd flags
    issue(7'h01, 3'b110, 32'd3, 32'd5, r, w, lat);
    check(r == 32'd0, "R11 rs2 invalid gives zero count", r, 32'd0);
    check(lat == 1, "R11 rs2 invalid latency", 32'(lat), 32'd1);
    expQ.push_back(modBuf[0]); expQ.push_back(modBuf[1]);
    issue(7'h01, 3'b001, 32'd40, 32'd2, r, w, lat);
    check(w == 1'b0, "R11 rd flag clear", 32'(w), 32'd0);
    check(r == 32'd2, "R11 rs1 invalid result", r, 32'd2);

    // R12 foreign opcode never acknowledged
    @(negedge clk);
    insnWord = {7'h01, 5'd2, 5'd1, 3'b111, 5'd3, 7'b0110011};
    opA = 0; opB = 4; insnValid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(insnReady == 1'b0, "R12 foreign opcode ignored", 32'(insnReady), 32'd0);
      check(cfgEn == 1'b0, "R12 no port cycle", 32'(cfgEn), 32'd0);
    end
    insnValid = 1'b0;

    // R6 streaming with an empty-FIFO stall
    pushWord(32'hC000_0001);
    pushWord(32'hC000_0002);
    for (int i = 1; i <= 6; i++) expQ.push_back(32'hC000_0000 + 32'(i));
    fork
      begin
        logic [31:0] sr; logic sw; int sl;
        issue(7'h03, 3'b111, 32'h1000, 32'd6, sr, sw, sl);
        check(sr == 32'd6, "R6 stream result", sr, 32'd6);
      end
      begin
        repeat (6) @(negedge clk);
        check(cfgEn == 1'b0, "R6 stalled while empty", 32'(cfgEn), 32'd0);
        check(insnReady == 1'b0, "R6 not retired while words remain", 32'(insnReady), 32'd0);
        for (int i = 3; i <= 6; i++) pushWord(32'hC000_0000 + 32'(i));
      end
    join

    // R7 full FIFO drops writes
    for (int i = 0; i < FDEPTH + 2; i++) begin
      pushWord(32'hD000_0000 + 32'(i));
      if (i == FDEPTH - 1) check(fifoFull == 1'b1, "R7 full at depth", 32'(fifoFull), 32'd1);
    end
    for (int i = 0; i < FDEPTH; i++) expQ.push_back(32'hD000_0000 + 32'(i));
    issue(7'h03, 3'b111, 32'd0, 32'(FDEPTH), r, w, lat);
    check(r == 32'(FDEPTH), "R7 drain result", r, 32'(FDEPTH));
    check(fifoFull == 1'b0, "R7 not full after drain", 32'(fifoFull), 32'd0);
    pushWord(32'hE000_0077);
    expQ.push_back(32'hE000_0077);
    issue(7'h03, 3'b111, 32'd0, 32'd1, r, w, lat);
    check(lat == 2, "R7 dropped word absent, single word latency", 32'(lat), 32'd2);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R3/R6 all expected writes seen", 32'(expQ.size()), 32'd0);
    check(expReads == 0, "R4 all expected reads seen", 32'(expReads), 32'd0);
    finished = 1;
    summary();
  end
endmodule